// File: doc/BRIEF.md
# Packet Replay Generator

This block stores a single packet in a local word buffer and sends it again and again on a streaming output. The host programs three things through one register write port: the buffer contents, the packet length and the spacing between packet starts. It then starts or stops the replay with a run bit. The output is a valid/ready stream, with markers on the first and last word of each packet.

The spacing is a number of clock cycles measured from one packet start to the next. If the spacing is shorter than the packet, the packets follow each other with no idle cycle. A stop never cuts a packet short. Backpressure holds the current word in place, while the spacing counter keeps running. The buffer and the length are frozen while the generator is busy: the block drops writes to them during that time and raises a sticky error flag.

Top module: `pkt_replay_gen`

## Requirements
- R1: After reset, outValid and errFlag are low and the run bit is clear. The length register selects 1 word and the interval register holds 0.
- R2: Register map on wrAddr when wrEn is high. Addresses 0 to 63 write buffer word wrAddr. Address 64 takes the packet length minus one from wrData[5:0]. Address 65 takes the interval in cycles from wrData[15:0]. Address 66 is control: wrData[0] is the run bit, and any write to it clears errFlag. A write to any other address has no effect.
- R3: Each packet carries buffer words 0 to L-1 in ascending order. outSop is high only with word 0 and outEop only with word L-1. Both markers are high on a one-word packet.
- R4: A control write with the run bit set in cycle c, made after the interval has run out since the last start, presents word 0 with outSop in cycle c+1.
- R5: With outReady held high and an interval I greater than L, successive packets start exactly I cycles apart.
- R6: With an interval no greater than L (including 0), the next packet starts in the cycle after the last word is accepted, so starts are L cycles apart.
- R7: Clearing the run bit lets the packet in flight finish in full and starts no further packet. This includes a stop written in the very cycle in which the last word is accepted.
- R8: While outValid is high and outReady is low, outValid, outData, outSop and outEop hold. The interval keeps counting during the stall, and the next start falls at the later of (previous start + I) and (cycle after the last word is accepted).
- R9: While the run bit is set or a packet is in flight, writes to buffer words or to the length register are dropped, and errFlag rises in the next cycle. errFlag stays high until a control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 7 | Register write address |
| wrData | input | 64 | Register write data |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream ready |
| outData | output | 64 | Output word |
| outSop | output | 1 | First word of packet |
| outEop | output | 1 | Last word of packet |
| errFlag | output | 1 | Sticky flag for a dropped write |

## Verification
The critical overlap is a stop command landing in the same cycle in which the last word is accepted while the interval has already run out. In that cycle the launch logic would otherwise start a new packet. The bench provokes this with a back-to-back three-word packet and a stop write timed to that final handshake. It then requires exactly one packet, with no trailing start. A second overlap is a stall that outlasts the interval, so that the end of the packet rather than the counter sets the next start. The bench judges it by the measured spacing between accepted start words.

// File: rtl/pkt_replay_pkg.sv
package pkt_replay_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic bufWe;    // store a buffer word
    logic lenWe;    // store packet length minus one
    logic ivlWe;    // store interval
    logic launch;   // begin a packet at the next edge
    logic advance;  // current word accepted downstream
  } strobe_t;

endpackage

// File: rtl/pkt_replay_dp.sv
module pkt_replay_dp
  import pkt_replay_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  parameter int IVL_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [$clog2(DEPTH)-1:0] wrIdx,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        wordOut,
  output logic                     firstWord,
  output logic                     lastWord,
  output logic                     gapDone
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = IVL_W + 1;

  logic [DATA_W-1:0] pktMem [DEPTH];
  logic [AW-1:0]     lenM1;
  logic [IVL_W-1:0]  ivl;
  logic [AW-1:0]     wordIdx;
  logic [CNT_W-1:0]  elapsed;
  logic [CNT_W:0]    elapsedNext;

  always_ff @(posedge clk) begin
    if (strb.bufWe) pktMem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenM1 <= '0;
      ivl   <= '0;
    end else begin
      if (strb.lenWe) lenM1 <= wrData[AW-1:0];
      if (strb.ivlWe) ivl   <= wrData[IVL_W-1:0];
    end
  end

  // word pointer: restart on launch, step on each accepted word
  always_ff @(posedge clk) begin
    if (!rstN)             wordIdx <= '0;
    else if (strb.launch)  wordIdx <= '0;
    else if (strb.advance) wordIdx <= wordIdx + 1'b1;
  end

  // cycles since the last packet start, saturating; runs through stalls
  always_ff @(posedge clk) begin
    if (!rstN)               elapsed <= '1;
    else if (strb.launch)    elapsed <= '0;
    else if (elapsed != '1)  elapsed <= elapsed + 1'b1;
  end

  always_comb begin
    elapsedNext = {1'b0, elapsed} + 1'b1;
    gapDone     = elapsedNext >= {{(CNT_W + 1 - IVL_W){1'b0}}, ivl};
    wordOut     = pktMem[wordIdx];
    firstWord   = wordIdx == '0;
    lastWord    = wordIdx == lenM1;
  end

endmodule

// File: rtl/pkt_replay_ctl.sv
module pkt_replay_ctl
  import pkt_replay_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [$clog2(DEPTH):0] wrAddr,
  input  logic                   wrRun,
  input  logic                   outReady,
  input  logic                   lastWord,
  input  logic                   gapDone,
  output strobe_t                strb,
  output logic                   sending,
  output logic                   errFlag
);

  localparam int ADDR_W = $clog2(DEPTH) + 1;

  logic runReq, runNext, busy, handshake, endAcc;
  logic isBuf, isLen, isIvl, isCtl, badWrite;

  always_comb begin
    isBuf = wrEn && !wrAddr[ADDR_W-1];
    isLen = wrEn && (wrAddr == ADDR_W'(DEPTH));
    isIvl = wrEn && (wrAddr == ADDR_W'(DEPTH + 1));
    isCtl = wrEn && (wrAddr == ADDR_W'(DEPTH + 2));
  end

  always_comb begin
    busy      = runReq || sending;
    handshake = sending && outReady;
    endAcc    = handshake && lastWord;
    badWrite  = (isBuf || isLen) && busy;
    // a control write in this cycle decides the boundary at once
    runNext   = isCtl ? wrRun : runReq;
    strb         = '0;
    strb.bufWe   = isBuf && !busy;
    strb.lenWe   = isLen && !busy;
    strb.ivlWe   = isIvl;
    strb.launch  = runNext && (!sending || endAcc) && gapDone;
    strb.advance = handshake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReq  <= 1'b0;
      sending <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      runReq <= runNext;
      if (strb.launch)  sending <= 1'b1;
      else if (endAcc)  sending <= 1'b0;
      if (isCtl)         errFlag <= 1'b0;
      else if (badWrite) errFlag <= 1'b1;
    end
  end

  // R9
  bad_write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr[ADDR_W-1] && sending) |=> errFlag);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(wrEn));

endmodule

// File: rtl/pkt_replay_gen.sv
module pkt_replay_gen
  import pkt_replay_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  parameter int IVL_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [$clog2(DEPTH):0] wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [DATA_W-1:0]      outData,
  output logic                   outSop,
  output logic                   outEop,
  output logic                   errFlag
);

  localparam int AW = $clog2(DEPTH);

  strobe_t strb;
  logic    sending, firstWord, lastWord, gapDone;

  pkt_replay_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrRun    (wrData[0]),
    .outReady (outReady),
    .lastWord (lastWord),
    .gapDone  (gapDone),
    .strb     (strb),
    .sending  (sending),
    .errFlag  (errFlag)
  );

  pkt_replay_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IVL_W(IVL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrIdx     (wrAddr[AW-1:0]),
    .wrData    (wrData),
    .wordOut   (outData),
    .firstWord (firstWord),
    .lastWord  (lastWord),
    .gapDone   (gapDone)
  );

  assign outValid = sending;
  assign outSop   = sending && firstWord;
  assign outEop   = sending && lastWord;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)
                                 && $stable(outSop) && $stable(outEop)));

  // R7
  no_truncation_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outEop) |=> outValid);

endmodule

// File: tb/test_pkt_replay_gen.sv
module test_pkt_replay_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic        outReady = 1'b1;
  logic        outValid, outSop, outEop, errFlag;
  logic [63:0] outData;

  int nChk = 0, nErr = 0, cyc = 0;
  int curL = 1, wIdx = 0, nSop = 0, nWords = 0;
  int sopT [8];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pkt_replay_gen i_pkt_replay_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outSop(outSop), .outEop(outEop), .errFlag(errFlag)
  );

  function automatic logic [63:0] pat(int l, int k);
    return {8'hA5, 8'(l), 16'(k), 32'(k * 32'h01010101) ^ 32'(l * 7)};
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = 7'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic monClear(input int l);
    curL = l; wIdx = 0; nSop = 0; nWords = 0;
  endtask

  // R3: every accepted word checked against order and markers
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      chk(outData == pat(curL, wIdx) && outSop == (wIdx == 0)
          && outEop == (wIdx == curL - 1),
          $sformatf("R3 word %0d of %0d (data/sop/eop %b%b)", wIdx, curL, outSop, outEop),
          outData, pat(curL, wIdx));
      if (wIdx == 0) begin
        if (nSop < 8) sopT[nSop] = cyc;
        nSop++;
      end
      nWords++;
      wIdx = (wIdx == curL - 1) ? 0 : wIdx + 1;
    end
  end

  task automatic load(input int l, input int ivl);
    wr(64, 64'(l - 1));
    wr(65, 64'(ivl));
    for (int k = 0; k < l; k++) wr(k, pat(l, k));
    monClear(l);
  endtask

  task automatic drain();
    repeat (24) @(posedge clk);
    @(negedge clk);
    chk(wIdx == 0, "R7 no truncated packet", 64'(wIdx), 0);
    chk(!outValid, "R7 idle after stop", 64'(outValid), 0);
  endtask

  task automatic runCase(input int l, input int ivl);
    int sp;
    load(l, ivl);
    wr(66, 1);
    @(negedge clk);
    chk(outValid && outSop, "R4 start one cycle after run write", 64'(outValid), 1);
    while (nSop < 3) @(posedge clk);
    wr(66, 0);
    drain();
    sp = (ivl > l) ? ivl : l;
    for (int p = 1; p < 3; p++)
      chk(sopT[p] - sopT[p-1] == sp,
          $sformatf("%s spacing L=%0d I=%0d", (ivl > l) ? "R5" : "R6", l, ivl),
          64'(sopT[p] - sopT[p-1]), 64'(sp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(!outValid, "R1 valid low after reset", 64'(outValid), 0);
    chk(!errFlag, "R1 error low after reset", 64'(errFlag), 0);

    // R1: default length 1 and interval 0 give single-word back-to-back packets
    wr(0, pat(1, 0));
    monClear(1);
    wr(66, 1);
    while (nSop < 3) @(posedge clk);
    wr(66, 0);
    drain();
    chk(sopT[1] - sopT[0] == 1, "R1 default length/interval spacing",
        64'(sopT[1] - sopT[0]), 1);

    // R5 R6: sweep length and interval
    for (int l = 1; l <= 6; l++)
      for (int i = 0; i <= 8; i++)
        runCase(l, i);

    // R2: unused addresses leave all state untouched
    load(3, 5);
    wr(67, '1);
    wr(127, '1);
    monClear(3);
    wr(66, 1);
    while (nSop < 2) @(posedge clk);
    wr(66, 0);
    drain();
    chk(sopT[1] - sopT[0] == 5, "R2 interval unchanged by unused address",
        64'(sopT[1] - sopT[0]), 5);
    chk(!errFlag, "R2 unused address sets no error", 64'(errFlag), 0);

    // R7: stop written in the cycle the last word is accepted
    load(3, 0);
    wr(66, 1);
    @(posedge clk);
    wr(66, 0);
    drain();
    chk(nSop == 1, "R7 stop on last-word cycle", 64'(nSop), 1);
    chk(nWords == 3, "R7 full packet on stop", 64'(nWords), 3);

    // R7: stop mid-packet
    load(5, 0);
    wr(66, 1);
    wr(66, 0);
    drain();
    chk(nSop == 1 && nWords == 5, "R7 mid-packet stop completes", 64'(nWords), 5);

    // R8: long stall, packet end sets the next start (9 = 2 + 5 stalled + 2)
    load(4, 6);
    wr(66, 1);
    @(posedge clk); #1;
    @(posedge clk); #1 outReady = 1'b0;
    @(negedge clk);
    chk(outValid && outData == pat(4, 2), "R8 word held during stall", outData, pat(4, 2));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(outValid && outData == pat(4, 2) && !outEop, "R8 still held", outData, pat(4, 2));
    @(posedge clk); #1 outReady = 1'b1;
    while (nSop < 2) @(posedge clk);
    wr(66, 0);
    drain();
    chk(sopT[1] - sopT[0] == 9, "R8 long stall start spacing", 64'(sopT[1] - sopT[0]), 9);

    // R8: short stall, interval sets the next start
    load(4, 6);
    wr(66, 1);
    @(posedge clk); #1;
    @(posedge clk); #1 outReady = 1'b0;
    @(posedge clk); #1 outReady = 1'b1;
    while (nSop < 2) @(posedge clk);
    wr(66, 0);
    drain();
    chk(sopT[1] - sopT[0] == 6, "R8 short stall start spacing", 64'(sopT[1] - sopT[0]), 6);

    // R9: writes while running are dropped and flagged
    load(4, 12);
    wr(66, 1);
    wr(1, 64'hDEAD_BEEF_0BAD_F00D);
    @(negedge clk);
    chk(errFlag, "R9 error after buffer write while running", 64'(errFlag), 1);
    wr(64, 0);
    @(negedge clk);
    chk(errFlag, "R9 error stays after length write", 64'(errFlag), 1);
    while (nSop < 3) @(posedge clk);
    chk(nWords >= 8, "R9 packets keep original length", 64'(nWords), 8);
    wr(66, 1);
    @(negedge clk);
    chk(!errFlag, "R9 control write clears error", 64'(errFlag), 0);
    wr(66, 0);
    drain();

    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

endmodule